// File: doc/BRIEF.md
# Receive Mailbox Slot Allocator

This block sits between a CAN frame receiver and a bank of message mailboxes. It decides which mailbox takes an accepted frame. The bank holds `NUM_MB` mailboxes. The lowest `NUM_TX` indices are reserved for transmit and never receive. Every other index can receive. Each mailbox has four controls:

- an enable bit
- a direction bit
- an overwrite-protection bit
- an interrupt-mask bit

Each mailbox also has its own acceptance filter, made of a compare word and a don't-care mask.

When the receiver strobes a frame, the block forms the identifier word and the control word. It then writes the frame into the highest-numbered eligible mailbox and flags that mailbox as pending. A mailbox that already holds an unread frame is handled by its protection bit: if the bit is set, the mailbox is passed over; if it is clear, the mailbox is overwritten. If no mailbox can take the frame, the frame is discarded and a loss flag is raised. Software reads the stored frames back through a one-cycle read port. It acknowledges pending and loss flags by writing ones.

Top module: `rx_slot_alloc`

## Requirements
- R1: A frame presented with `frm_valid` is stored in the highest-numbered mailbox that meets all of the following: its enable bit is 1, its direction bit is 1 (receive), its filter matches, and it is not both pending and protected.
- R2: Mailbox indices below `NUM_TX` are never written. A frame for which only those mailboxes would qualify causes no write and changes no loss flag.
- R3: Storing a frame sets that mailbox's bit in `rx_pending`. A 1 written on `pend_clr` clears the bit. When a set and a clear hit the same bit in the same cycle, the set wins.
- R4: A mailbox whose `rx_pending` bit is 1 and whose `mb_protect` bit is 1 is skipped, and the next lower eligible mailbox receives the frame.
- R5: A mailbox whose `rx_pending` bit is 1 and whose `mb_protect` bit is 0 is overwritten, and its `msg_lost` bit is set.
- R6: A frame is dropped when it has candidates (enabled, receive, matching, index at least `NUM_TX`) but all of them are pending and protected. A dropped frame produces no write and sets the `msg_lost` bit of the lowest-numbered candidate. A 1 on `lost_clr` clears a `msg_lost` bit.
- R7: The stored identifier word has the following layout:
  - Extended frame: bit 31 is 1 and bits 28:0 hold the 29-bit ID.
  - Standard frame: the 11-bit ID sits in bits 28:18 and all other bits are 0.
- R8: The stored control word has the remote-request flag in bit 4, the length in bits 3:0, and zeros above.
- R9: Clearing a mailbox's enable bit removes it from allocation on the next frame and leaves its stored words unchanged.
- R10: Acceptance: a mailbox matches when the frame's identifier word equals the filter word in every bit where the filter mask is 0. After reset every mask is all ones, so every mailbox accepts every frame.
- R11: `rx_irq_vec` is `rx_pending & mb_irq_mask`, and `rx_irq` is 1 while any bit of that vector is 1.
- R12: The `st_*` outputs present a store in the cycle after the frame strobe. The read port returns a mailbox's stored words one cycle after `rd_idx` is applied.
- R13: After reset, `rx_pending`, `msg_lost`, `st_we` and `rx_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: accepted frame present |
| frm_ext | input | 1 | Frame uses a 29-bit identifier |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_id | input | 29 | Identifier (low 11 bits used for standard frames) |
| frm_len | input | 4 | Data length code |
| frm_data | input | 64 | Eight payload bytes |
| mb_enable | input | NUM_MB | Per-mailbox enable |
| mb_rx_dir | input | NUM_MB | Per-mailbox direction, 1 = receive |
| mb_protect | input | NUM_MB | Per-mailbox overwrite protection |
| mb_irq_mask | input | NUM_MB | Per-mailbox interrupt mask |
| pend_clr | input | NUM_MB | Write-one-to-clear for pending bits |
| lost_clr | input | NUM_MB | Write-one-to-clear for loss bits |
| flt_we | input | 1 | Filter write strobe |
| flt_sel | input | IW | Mailbox whose filter is written |
| flt_word | input | 32 | Filter compare word |
| flt_mask | input | 32 | Filter don't-care mask, 1 = ignore bit |
| rd_idx | input | IW | Mailbox to read back |
| rd_id_word | output | 32 | Stored identifier word |
| rd_ctl_word | output | 32 | Stored control word |
| rd_data | output | 64 | Stored payload |
| st_we | output | 1 | A store happened on the previous edge |
| st_idx | output | IW | Mailbox written |
| st_id_word | output | 32 | Identifier word written |
| st_ctl_word | output | 32 | Control word written |
| st_data | output | 64 | Payload written |
| rx_pending | output | NUM_MB | Receive-pending flags |
| msg_lost | output | NUM_MB | Message-lost flags |
| rx_irq_vec | output | NUM_MB | Per-mailbox receive interrupt |
| rx_irq | output | 1 | Any receive interrupt |

## Verification
The hardest state to reach from the ports is a bank in which every receive mailbox is pending and protected, since only that state produces a drop and a loss flag on the lowest candidate. The stimulus gets there by streaming enough frames to fill every receive index down to `NUM_TX`, checking each landing slot on the way. With the bank full, it frees a single mid-bank slot to show that the full mailboxes above it are skipped. It then lifts protection on the top slot to force an overwrite.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

  localparam int ID_W   = 29;
  localparam int STD_W  = 11;
  localparam int WORD_W = 32;
  localparam int DATA_W = 64;
  localparam int LEN_W  = 4;
  localparam int STD_SHIFT = 18;
  localparam int EXT_FLAG_BIT = 31;
  localparam int RTR_BIT = 4;

  function automatic logic [WORD_W-1:0] pack_id_word(input logic ext,
                                                     input logic [ID_W-1:0] id);
    logic [WORD_W-1:0] w;
    w = '0;
    if (ext) begin
      w[ID_W-1:0] = id;
      w[EXT_FLAG_BIT] = 1'b1;
    end else begin
      w[STD_SHIFT +: STD_W] = id[STD_W-1:0];
    end
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_ctl_word(input logic rtr,
                                                      input logic [LEN_W-1:0] len);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LEN_W-1:0] = len;
    w[RTR_BIT] = rtr;
    return w;
  endfunction

endpackage

// File: rtl/rxa_pick.sv
module rxa_pick #(
  parameter int N    = 32,
  parameter bit HIGH = 1'b1,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  assign any = |req;

  generate
    if (HIGH) begin : g_high
      always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
          if (req[i]) idx = IW'(i);
        end
      end
    end else begin : g_low
      always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
          if (req[i]) idx = IW'(i);
        end
      end
    end
  endgenerate

  // R1: the chosen index is one that was requested
  always_comb begin
    if (any) a_r1_pick_is_request: assert (req[idx]);
  end

endmodule

// File: rtl/rxa_filter.sv
module rxa_filter
  import rxa_pkg::*;
#(
  parameter int N   = 32,
  localparam int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IW-1:0]     sel,
  input  logic [WORD_W-1:0] word_in,
  input  logic [WORD_W-1:0] mask_in,
  input  logic [WORD_W-1:0] frame_word,
  output logic [N-1:0]      match
);

  generate
    for (genvar g = 0; g < N; g++) begin : g_flt
      logic [WORD_W-1:0] cmp_q;
      logic [WORD_W-1:0] dc_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cmp_q <= '0;
          dc_q  <= '1;
        end else if (we && sel == IW'(g)) begin
          cmp_q <= word_in;
          dc_q  <= mask_in;
        end
      end

      assign match[g] = ((frame_word ^ cmp_q) & ~dc_q) == '0;

      // R10: a fully don't-care filter always matches
      always_comb begin
        if (dc_q == '1) a_r10_open_filter_matches: assert (match[g]);
      end
    end
  endgenerate

endmodule

// File: rtl/rxa_store.sv
module rxa_store
  import rxa_pkg::*;
#(
  parameter int N   = 32,
  localparam int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IW-1:0]     widx,
  input  logic [WORD_W-1:0] id_in,
  input  logic [WORD_W-1:0] ctl_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [IW-1:0]     ridx,
  output logic [WORD_W-1:0] id_out,
  output logic [WORD_W-1:0] ctl_out,
  output logic [DATA_W-1:0] data_out
);

  logic [WORD_W-1:0] id_mem   [N];
  logic [WORD_W-1:0] ctl_mem  [N];
  logic [DATA_W-1:0] data_mem [N];

  always_ff @(posedge clk) begin
    if (we) begin
      id_mem[widx]   <= id_in;
      ctl_mem[widx]  <= ctl_in;
      data_mem[widx] <= data_in;
    end
    id_out   <= id_mem[ridx];
    ctl_out  <= ctl_mem[ridx];
    data_out <= data_mem[ridx];
  end

endmodule

// File: rtl/rx_slot_alloc.sv
module rx_slot_alloc
  import rxa_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int NUM_TX = 4,
  localparam int IW    = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid,
  input  logic              frm_ext,
  input  logic              frm_rtr,
  input  logic [28:0]       frm_id,
  input  logic [3:0]        frm_len,
  input  logic [63:0]       frm_data,
  input  logic [NUM_MB-1:0] mb_enable,
  input  logic [NUM_MB-1:0] mb_rx_dir,
  input  logic [NUM_MB-1:0] mb_protect,
  input  logic [NUM_MB-1:0] mb_irq_mask,
  input  logic [NUM_MB-1:0] pend_clr,
  input  logic [NUM_MB-1:0] lost_clr,
  input  logic              flt_we,
  input  logic [IW-1:0]     flt_sel,
  input  logic [31:0]       flt_word,
  input  logic [31:0]       flt_mask,
  input  logic [IW-1:0]     rd_idx,
  output logic [31:0]       rd_id_word,
  output logic [31:0]       rd_ctl_word,
  output logic [63:0]       rd_data,
  output logic              st_we,
  output logic [IW-1:0]     st_idx,
  output logic [31:0]       st_id_word,
  output logic [31:0]       st_ctl_word,
  output logic [63:0]       st_data,
  output logic [NUM_MB-1:0] rx_pending,
  output logic [NUM_MB-1:0] msg_lost,
  output logic [NUM_MB-1:0] rx_irq_vec,
  output logic              rx_irq
);

  localparam logic [NUM_MB-1:0] RX_RANGE = {{(NUM_MB-NUM_TX){1'b1}}, {NUM_TX{1'b0}}};

  logic [WORD_W-1:0] id_word, ctl_word;
  logic [NUM_MB-1:0] match, cand, elig;
  logic              win_any, cand_any;
  logic [IW-1:0]     win_idx, low_idx;
  logic [NUM_MB-1:0] set_vec, lost_set;

  assign id_word  = pack_id_word(frm_ext, frm_id);
  assign ctl_word = pack_ctl_word(frm_rtr, frm_len);

  rxa_filter #(.N(NUM_MB)) u_filter (
    .clk(clk), .rst(rst), .we(flt_we), .sel(flt_sel),
    .word_in(flt_word), .mask_in(flt_mask),
    .frame_word(id_word), .match(match)
  );

  assign cand = frm_valid ? (mb_enable & mb_rx_dir & match & RX_RANGE) : '0;
  assign elig = cand & ~(rx_pending & mb_protect);

  rxa_pick #(.N(NUM_MB), .HIGH(1'b1)) u_pick_win (
    .req(elig), .any(win_any), .idx(win_idx)
  );

  rxa_pick #(.N(NUM_MB), .HIGH(1'b0)) u_pick_low (
    .req(cand), .any(cand_any), .idx(low_idx)
  );

  always_comb begin
    set_vec  = '0;
    lost_set = '0;
    if (win_any) begin
      set_vec[win_idx] = 1'b1;
      if (rx_pending[win_idx]) lost_set[win_idx] = 1'b1;
    end else if (cand_any) begin
      lost_set[low_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_pending <= '0;
      msg_lost   <= '0;
      st_we      <= 1'b0;
      st_idx     <= '0;
    end else begin
      rx_pending <= (rx_pending & ~pend_clr) | set_vec;
      msg_lost   <= (msg_lost & ~lost_clr) | lost_set;
      st_we      <= win_any;
      st_idx     <= win_idx;
    end
  end

  always_ff @(posedge clk) begin
    st_id_word  <= id_word;
    st_ctl_word <= ctl_word;
    st_data     <= frm_data;
  end

  rxa_store #(.N(NUM_MB)) u_store (
    .clk(clk), .we(win_any), .widx(win_idx),
    .id_in(id_word), .ctl_in(ctl_word), .data_in(frm_data),
    .ridx(rd_idx), .id_out(rd_id_word), .ctl_out(rd_ctl_word), .data_out(rd_data)
  );

  assign rx_irq_vec = rx_pending & mb_irq_mask;
  assign rx_irq     = |rx_irq_vec;

  // Checking state: mailboxes that were full and protected before the last edge
  logic [NUM_MB-1:0] prot_full_q;
  always_ff @(posedge clk) begin
    if (rst) prot_full_q <= '0;
    else     prot_full_q <= rx_pending & mb_protect;
  end

  a_r2_no_tx_store: assert property (@(posedge clk) disable iff (rst)
    st_we |-> (st_idx >= IW'(NUM_TX)));

  a_r3_pending_after_store: assert property (@(posedge clk) disable iff (rst)
    st_we |-> rx_pending[st_idx]);

  a_r4_protected_not_written: assert property (@(posedge clk) disable iff (rst)
    st_we |-> !prot_full_q[st_idx]);

  a_r6_lost_only_from_frame: assert property (@(posedge clk) disable iff (rst)
    (|(msg_lost & ~$past(msg_lost))) |-> $past(frm_valid));

endmodule

// File: tb/rx_slot_alloc_test.sv
`timescale 1ns/1ps
module rx_slot_alloc_test;

  localparam int N  = 32;
  localparam int NT = 4;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          frm_valid = 0, frm_ext = 0, frm_rtr = 0;
  logic [28:0]   frm_id = '0;
  logic [3:0]    frm_len = '0;
  logic [63:0]   frm_data = '0;
  logic [N-1:0]  mb_enable = '1, mb_rx_dir = '1, mb_protect = '1, mb_irq_mask = '0;
  logic [N-1:0]  pend_clr = '0, lost_clr = '0;
  logic          flt_we = 0;
  logic [IW-1:0] flt_sel = '0, rd_idx = '0;
  logic [31:0]   flt_word = '0, flt_mask = '1;
  logic [31:0]   rd_id_word, rd_ctl_word, st_id_word, st_ctl_word;
  logic [63:0]   rd_data, st_data;
  logic          st_we, rx_irq;
  logic [IW-1:0] st_idx;
  logic [N-1:0]  rx_pending, msg_lost, rx_irq_vec;

  rx_slot_alloc #(.NUM_MB(N), .NUM_TX(NT)) uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // vector: {ext, rtr, id[28:0], len[3:0]}
  localparam logic [34:0] VEC [8] = '{
    {1'b0, 1'b0, 29'h123,      4'd8},
    {1'b1, 1'b0, 29'h1ABCDEF,  4'd4},
    {1'b0, 1'b1, 29'h7FF,      4'd0},
    {1'b1, 1'b0, 29'h1FFFFFFF, 4'd15},
    {1'b0, 1'b0, 29'h000,      4'd1},
    {1'b1, 1'b1, 29'h0000001,  4'd2},
    {1'b0, 1'b0, 29'h555,      4'd7},
    {1'b1, 1'b0, 29'h0AAAAAAA, 4'd8}
  };

  function automatic logic [31:0] exp_id(input logic ext, input logic [28:0] id);
    if (ext) return 32'h8000_0000 | {3'b000, id};
    return {3'b000, id[10:0], 18'd0};
  endfunction

  function automatic logic [31:0] exp_ctl(input logic rtr, input logic [3:0] len);
    return {27'd0, rtr, len};
  endfunction

  function automatic logic [63:0] pay(input int k);
    return {8{8'(k)}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic send(input logic ext, input logic rtr, input logic [28:0] id,
                      input logic [3:0] len, input logic [63:0] d, input logic [N-1:0] clr);
    @(negedge clk);
    frm_valid = 1; frm_ext = ext; frm_rtr = rtr; frm_id = id; frm_len = len;
    frm_data = d; pend_clr = clr;
    @(posedge clk); #1;
    frm_valid = 0; pend_clr = '0;
  endtask

  task automatic clr_pend(input logic [N-1:0] v);
    @(negedge clk); pend_clr = v;
    @(posedge clk); #1; pend_clr = '0;
  endtask

  task automatic clr_lost(input logic [N-1:0] v);
    @(negedge clk); lost_clr = v;
    @(posedge clk); #1; lost_clr = '0;
  endtask

  task automatic rd(input int i);
    @(negedge clk); rd_idx = IW'(i);
    @(posedge clk); #1;
  endtask

  task automatic set_filter(input int i, input logic [31:0] w, input logic [31:0] m);
    @(negedge clk); flt_we = 1; flt_sel = IW'(i); flt_word = w; flt_mask = m;
    @(posedge clk); #1; flt_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R13 reset state
    chk("R13 pending", rx_pending, '0);
    chk("R13 lost", msg_lost, '0);
    chk("R13 st_we", st_we, 0);
    chk("R13 irq", rx_irq, 0);
    @(negedge clk); rst = 0;

    // Table walk: bank empty, all open, all protected
    for (int k = 0; k < 8; k++) begin
      send(VEC[k][34], VEC[k][33], VEC[k][32:4], VEC[k][3:0], pay(k), '0);
      chk("R12 st_we", st_we, 1);
      chk("R1 slot", st_idx, 64'(31 - k));
      chk("R7 id word", st_id_word, exp_id(VEC[k][34], VEC[k][32:4]));
      chk("R8 ctl word", st_ctl_word, exp_ctl(VEC[k][33], VEC[k][3:0]));
      chk("R12 st_data", st_data, pay(k));
      chk("R3 pending set", rx_pending[31-k], 1);
    end

    // Fill the rest down to the lowest receive mailbox (R4 skipping)
    for (int j = 8; j < 28; j++) begin
      send(0, 0, 29'(j), 4'd1, pay(j), '0);
      if (j == 27) chk("R4 last slot", st_idx, 4);
    end
    chk("R2 pending full RX only", rx_pending, 32'hFFFF_FFF0);

    // Drop: all candidates full and protected
    send(0, 0, 29'h42, 4'd3, pay(40), '0);
    chk("R6 no write on drop", st_we, 0);
    chk("R6 lost lowest cand", msg_lost, 32'h0000_0010);
    chk("R6 pending unchanged", rx_pending, 32'hFFFF_FFF0);
    clr_lost(32'h0000_0010);
    chk("R6 lost cleared", msg_lost, '0);

    // Free slot 20, next frame skips full protected 31..21
    clr_pend(32'h0010_0000);
    chk("R3 pending clear", rx_pending[20], 0);
    send(0, 0, 29'h99, 4'd2, pay(41), '0);
    chk("R4 skip to 20", st_idx, 20);

    // Overwrite unprotected full 31
    mb_protect[31] = 0;
    send(1, 0, 29'h55, 4'd6, pay(42), '0);
    chk("R5 overwrite slot", st_idx, 31);
    chk("R5 lost set", msg_lost, 32'h8000_0000);
    rd(31);
    chk("R12 read id", rd_id_word, exp_id(1, 29'h55));
    chk("R12 read data", rd_data, pay(42));

    // Disable 31: frame goes to 30, 31 contents kept
    mb_protect = '1;
    clr_pend('1);
    mb_enable[31] = 0;
    send(0, 1, 29'h321, 4'd5, pay(43), '0);
    chk("R9 disabled skipped", st_idx, 30);
    rd(31);
    chk("R9 contents kept id", rd_id_word, exp_id(1, 29'h55));
    chk("R9 contents kept ctl", rd_ctl_word, exp_ctl(0, 4'd6));

    // Filter on 30: exact standard ID 0x123
    clr_pend('1);
    set_filter(30, exp_id(0, 29'h123), 32'h0);
    send(0, 0, 29'h124, 4'd1, pay(44), '0);
    chk("R10 mismatch passes by", st_idx, 29);
    clr_pend('1);
    send(0, 0, 29'h123, 4'd1, pay(45), '0);
    chk("R10 match lands", st_idx, 30);
    clr_pend('1);
    mb_rx_dir[30] = 0;
    send(0, 0, 29'h123, 4'd1, pay(46), '0);
    chk("R1 transmit-direction skipped", st_idx, 29);

    // Interrupt (pending = bit 29 only)
    @(negedge clk); mb_irq_mask = 32'h1000_0000; #1;
    chk("R11 masked off", rx_irq, 0);
    @(negedge clk); mb_irq_mask = 32'h2000_0000; #1;
    chk("R11 asserted", rx_irq, 1);
    chk("R11 vec", rx_irq_vec, 32'h2000_0000);
    clr_pend(32'h2000_0000);
    chk("R11 drops after clear", rx_irq, 0);

    // Set and clear of the same bit together: set wins
    send(0, 0, 29'h10, 4'd1, pay(47), 32'h2000_0000);
    chk("R3 set wins", rx_pending[29], 1);

    // Only transmit mailboxes enabled: nothing happens
    clr_pend('1);
    mb_enable = 32'h0000_000F;
    send(0, 0, 29'h11, 4'd1, pay(48), '0);
    chk("R2 no tx write", st_we, 0);
    chk("R2 lost unchanged", msg_lost, 32'h8000_0000);
    chk("R2 pending none", rx_pending, '0);

    finish_run();
  end

endmodule